// File: doc/BRIEF.md
# Prefixed Instruction Fetch Sequencer

This block sits between instruction fetch and decode in a core whose instruction set allows a 64-bit instruction made of a 32-bit prefix word followed by a 32-bit suffix word. Fetch delivers 32-bit words in program order over a valid/ready handshake. The sequencer looks at each word's top opcode bits. A prefix word is not sent on by itself. Instead, its 24-bit mode field is captured internally and the sequencer waits for the next word. That next word then leaves as one 56-bit bundle, with the captured field in the upper bits and the 32-bit word in the lower bits, marked as prefixed.

Interrupt delivery is blocked for the whole time a field is held. Because of this, the held field never has to be saved or restored on an exception and never becomes architectural state. A word that is not preceded by a prefix is passed on untouched, with a zero upper field and the prefixed flag clear. A second prefix arriving while a field is held is reported as illegal. A flush, for example after a redirect, drops everything held in the block and unblocks interrupts in the same cycle.

Top module: `pfx_fetch_seq`

## Requirements
- R1: After synchronous reset: out_valid=0, irq_mask=0, in_ready=1, and no field is held.
- R2: An accepted word whose bits [31:26] are not 6'd9, arriving while no field is held, appears on the next cycle with out_valid=1, out_bundle={24'h0, word}, out_prefixed=0 and out_illegal=0.
- R3: An accepted word with bits [31:26]==6'd9, arriving while no field is held, produces no output. Its bits [23:0] are held, and irq_mask is 1 from the next cycle.
- R4: The next accepted non-prefix word appears one cycle later as out_bundle={held[23:0], word} with out_prefixed=1. In that same cycle irq_mask is 0, and the held field is cleared.
- R5: irq_mask stays 1 for as long as a field is held, whatever the number of idle input cycles.
- R6: in_ready = !flush && (!out_valid || out_ready). While out_valid=1 and out_ready=0, out_bundle and the flags hold their values.
- R7: While flush=1, irq_mask is 0 in that same cycle. On the next cycle out_valid=0 and no field is held, so the next non-prefix word leaves unprefixed.
- R8: A prefix word accepted while a field is held appears as out_bundle={24'h0, word} with out_illegal=1 and out_prefixed=0. The held field is dropped, and irq_mask is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop held field and pending output |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Sequencer can take a word |
| in_word | input | 32 | Fetched instruction word |
| out_valid | output | 1 | Bundle valid towards decode |
| out_ready | input | 1 | Decode accepts bundle |
| out_bundle | output | 56 | {mode field[23:0], word[31:0]} |
| out_prefixed | output | 1 | Bundle carries a prefix field |
| out_illegal | output | 1 | Back-to-back prefix detected |
| irq_mask | output | 1 | Interrupts blocked while a field is held |

## Verification
If the held-field state is wrong, it shows at the ports on the very next bundle. A stale field turns up in the upper 24 bits of an unprefixed word, or a dropped field clears out_prefixed where it should be set. The same fault also shows on irq_mask one cycle after the handshake that should have changed it. A wrong output-stage state appears as a bundle that changes during a stall, or as an in_ready that disagrees with the out_valid/out_ready pair in the same cycle. The bench compares every port on every cycle against an independent model, so any such error is reported within one cycle of the fault.

// File: rtl/pfx_seq_pkg.sv
package pfx_seq_pkg;
    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 24;
    localparam int OPC_W    = 6;
    localparam int BUNDLE_W = FIELD_W + WORD_W;
    localparam logic [OPC_W-1:0] PFX_OPC = 6'd9;

    typedef enum logic {ST_IDLE, ST_HOLD} seq_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic [WORD_W-1:0]  word;
    } bundle_t;

    typedef struct packed {
        bundle_t bundle;
        logic    prefixed;
        logic    illegal;
    } issue_t;

    function automatic logic is_prefix_word(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: OPC_W] == PFX_OPC;
    endfunction
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_seq_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output logic               is_pfx,
    output logic [FIELD_W-1:0] field
);
    always_comb begin
        is_pfx = is_prefix_word(word);
        field  = word[FIELD_W-1:0];
    end
endmodule

// File: rtl/pfx_hold_fsm.sv
module pfx_hold_fsm
    import pfx_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               accept,
    input  logic               is_pfx,
    input  logic [FIELD_W-1:0] field_in,
    input  logic [WORD_W-1:0]  word_in,
    output logic               holding,
    output logic               emit,
    output issue_t             emit_item
);
    seq_state_e         state_q;
    logic [FIELD_W-1:0] field_q;

    assign holding = (state_q == ST_HOLD);

    always_comb begin
        emit                      = 1'b0;
        emit_item.bundle.field    = '0;
        emit_item.bundle.word     = word_in;
        emit_item.prefixed        = 1'b0;
        emit_item.illegal         = 1'b0;
        if (accept) begin
            if (state_q == ST_IDLE) begin
                emit = !is_pfx;
            end else begin
                emit = 1'b1;
                if (is_pfx) begin
                    emit_item.illegal = 1'b1;
                end else begin
                    emit_item.bundle.field = field_q;
                    emit_item.prefixed     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= ST_IDLE;
            field_q <= '0;
        end else if (accept) begin
            if (state_q == ST_IDLE && is_pfx) begin
                state_q <= ST_HOLD;
                field_q <= field_in;
            end else begin
                state_q <= ST_IDLE;
                field_q <= '0;
            end
        end
    end

    // R3: a prefix taken in idle leads to the holding state
    a_r3_enter_hold: assert property (@(posedge clk) disable iff (rst)
        (!flush && accept && is_pfx && !holding) |=> holding);
    // R8: a second prefix drops the held field
    a_r8_double_prefix_drops: assert property (@(posedge clk) disable iff (rst)
        (!flush && accept && is_pfx && holding) |=> !holding);
    // R5: nothing leaves the holding state without a handshake or flush
    a_r5_hold_persists: assert property (@(posedge clk) disable iff (rst)
        (holding && !accept && !flush) |=> holding && $stable(field_q));
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage
    import pfx_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   load,
    input  issue_t load_item,
    input  logic   out_ready,
    output logic   out_valid,
    output issue_t out_item,
    output logic   can_take
);
    issue_t item_q;
    logic   valid_q;

    assign can_take  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_item  = item_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= 1'b0;
            item_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            item_q  <= load_item;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    // R6: a stalled bundle stays put
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !out_ready && !flush) |=> valid_q && $stable(item_q));
    // R7: flush empties the output stage
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !valid_q);
endmodule

// File: rtl/pfx_fetch_seq.sv
module pfx_fetch_seq
    import pfx_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BUNDLE_W-1:0] out_bundle,
    output logic                out_prefixed,
    output logic                out_illegal,
    output logic                irq_mask
);
    logic               is_pfx;
    logic [FIELD_W-1:0] field;
    logic               holding;
    logic               emit;
    logic               can_take;
    logic               accept;
    issue_t             emit_item;
    issue_t             out_item;

    assign in_ready = can_take && !flush;
    assign accept   = in_valid && in_ready;
    assign irq_mask = holding && !flush;

    pfx_classify u_cls (
        .word   (in_word),
        .is_pfx (is_pfx),
        .field  (field)
    );

    pfx_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .accept    (accept),
        .is_pfx    (is_pfx),
        .field_in  (field),
        .word_in   (in_word),
        .holding   (holding),
        .emit      (emit),
        .emit_item (emit_item)
    );

    pfx_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .load      (emit),
        .load_item (emit_item),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_item  (out_item),
        .can_take  (can_take)
    );

    assign out_bundle   = out_item.bundle;
    assign out_prefixed = out_item.prefixed;
    assign out_illegal  = out_item.illegal;

    // R4: interrupts are open whenever a combined bundle is presented
    a_r4_unmasked_with_bundle: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_prefixed) |-> !irq_mask);
    // R2: an unprefixed bundle carries a zero upper field
    a_r2_plain_zero_field: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_prefixed) |-> (out_bundle[BUNDLE_W-1:WORD_W] == '0));
    // R8: illegal and prefixed are never both set
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_prefixed && out_illegal));
endmodule

// File: tb/pfx_fetch_seq_test.sv
`timescale 1ns/1ps
module pfx_fetch_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [55:0] out_bundle;
    logic        out_prefixed;
    logic        out_illegal;
    logic        irq_mask;

    always #4 clk = ~clk;

    pfx_fetch_seq uut (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_bundle(out_bundle),
        .out_prefixed(out_prefixed), .out_illegal(out_illegal),
        .irq_mask(irq_mask)
    );

    int vectors = 0;
    int errors  = 0;

    // reference model state
    logic        m_hold = 0;
    logic [23:0] m_field = '0;
    logic        m_valid = 0;
    logic [55:0] m_bundle = '0;
    logic        m_pfx = 0;
    logic        m_ill = 0;
    logic        prev_flush = 0;
    logic        prev_pfx_take = 0;

    function automatic logic is_pfx(input logic [31:0] w);
        return w[31:26] == 6'd9;
    endfunction

    function automatic logic exp_ready(input logic fl, input logic v, input logic r);
        return !fl && (!v || r);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [55:0] got, input logic [55:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic iv, input logic [31:0] w,
                        input logic ordy, input logic fl);
        logic ir, acc;
        string vt;
        @(negedge clk);
        in_valid = iv; in_word = w; out_ready = ordy; flush = fl;
        #1;
        ir  = exp_ready(fl, m_valid, ordy);
        acc = iv && ir;
        vt  = prev_flush ? "R7" : (m_ill ? "R8" : (m_pfx ? "R4" : "R2"));
        check("R6", "in_ready", {55'd0, in_ready}, {55'd0, ir});
        check(fl ? "R7" : (prev_pfx_take ? "R3" : "R5"), "irq_mask",
              {55'd0, irq_mask}, {55'd0, m_hold && !fl});
        check(vt, "out_valid", {55'd0, out_valid}, {55'd0, m_valid});
        if (m_valid) begin
            check(vt, "out_bundle", out_bundle, m_bundle);
            check(vt, "out_prefixed", {55'd0, out_prefixed}, {55'd0, m_pfx});
            check(vt, "out_illegal", {55'd0, out_illegal}, {55'd0, m_ill});
        end
        prev_flush    = fl;
        prev_pfx_take = acc && !m_hold && is_pfx(w);
        if (fl) begin
            m_hold = 0; m_field = '0; m_valid = 0;
        end else begin
            if (m_valid && ordy) m_valid = 0;
            if (acc) begin
                if (!m_hold) begin
                    if (is_pfx(w)) begin
                        m_hold = 1; m_field = w[23:0];
                    end else begin
                        m_valid = 1; m_bundle = {24'h0, w}; m_pfx = 0; m_ill = 0;
                    end
                end else begin
                    m_valid = 1;
                    if (is_pfx(w)) begin
                        m_bundle = {24'h0, w}; m_pfx = 0; m_ill = 1;
                    end else begin
                        m_bundle = {m_field, w}; m_pfx = 1; m_ill = 0;
                    end
                    m_hold = 0; m_field = '0;
                end
            end
        end
    endtask

    function automatic logic [31:0] mk_pfx(input logic [25:0] low);
        return {6'd9, low};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "out_valid", {55'd0, out_valid}, 56'd0);
        check("R1", "irq_mask", {55'd0, irq_mask}, 56'd0);
        check("R1", "in_ready", {55'd0, in_ready}, 56'd1);

        // R2: plain word
        step(1, 32'h1234_5678, 1, 0);
        step(0, 0, 1, 0);
        // R3/R4: prefix then suffix
        step(1, mk_pfx(26'h0ABCDEF), 1, 0);
        step(0, 0, 1, 0);
        // R5: long wait while holding
        for (int i = 0; i < 6; i++) step(0, 32'hFFFF_FFFF, 1, 0);
        step(1, 32'h8000_0001, 1, 0);
        step(0, 0, 1, 0);
        // R6: stall the output
        step(1, 32'h4444_0000, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 32'h5555_0000, 0, 0);
        step(0, 0, 1, 0);
        // R8: back-to-back prefix
        step(1, mk_pfx(26'h3FFFFFF), 1, 0);
        step(1, mk_pfx(26'h0000001), 1, 0);
        step(1, 32'h0000_0042, 1, 0);
        step(0, 0, 1, 0);
        // R7: flush while holding, then a plain word
        step(1, mk_pfx(26'h0123456), 1, 0);
        step(0, 0, 1, 1);
        step(1, 32'h7777_7777, 1, 0);
        step(0, 0, 1, 0);
        // R7: flush with a pending bundle
        step(1, 32'h0BAD_F00D, 0, 0);
        step(1, 32'h0000_0001, 0, 1);
        step(0, 0, 1, 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 9) < 3) w[31:26] = 6'd9;
            step($urandom_range(0, 9) < 7, w, $urandom_range(0, 9) < 7,
                 $urandom_range(0, 99) < 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule